// File: doc/BRIEF.md
# Multiplexed Link Slot and Phase Aligner

This block performs the start-up alignment of a time-multiplexed analog link whose multiplexer clock comes from the receiver. During training, one multiplexer input is biased to a distinct level and every other input is held at a common level. The block watches the stream of ADC samples and finds the slot position that carries the first multiplexer channel. It then moves the multiplexer clock phase one step at a time through an external phase shifter, using an increment/decrement request with an acknowledge. This sweep locates the two phases at which the sampling point reaches a switching transient, and the block reports the phase halfway between them.

The quality figure at each phase setting is the channel-1 contrast. It is taken over a fixed number of whole frames as the sum of |(SLOTS-1)·x_ch1 − Σ x_other|. This is the mean absolute difference between the channel-1 sample and the average of the other slots, scaled by a constant. The first measurement, taken at the starting phase, is the reference. An edge is any phase whose contrast is at most half of that reference. The phase position wraps modulo the number of steps in one multiplexer clock period. If a sweep finds no edge within one full period, the block stops and flags an error.

Top module: `tdm_link_aligner`

## Requirements
- R1: After reset, step_inc, step_dec, done and err are all 0, and no request is raised until start is seen.
- R2: Slot indices count valid samples modulo SLOTS, and the first valid sample after the start cycle is slot 0. After NF frames, slot_ofs is the slot whose sum differs most from the mean of all slots, whichever sign that difference has.
- R3: The contrast at a phase is measured over NF whole frames. Each frame begins at a slot-0 sample that arrives after the measurement was launched. The first contrast is taken at the starting phase and becomes the reference.
- R4: The block first raises step_inc repeatedly and measures after each acknowledged step. The first position whose contrast is at most half the reference is kept as the left edge.
- R5: The block then raises step_dec repeatedly. The right edge is the first position with contrast at most half the reference, found after at least one position above half has been seen during this sweep.
- R6: Positions start at 0, go up by 1 per acknowledged increment and down by 1 per acknowledged decrement, and wrap modulo PSTEPS. phase_opt = (right + ((left − right) mod PSTEPS) / 2) mod PSTEPS, with the division truncating.
- R7: A request stays high until step_ack is seen with it. It drops in the cycle after the acknowledge. Only one step is taken per acknowledge, and step_inc and step_dec are never high together.
- R8: If a sweep takes PSTEPS steps without finding its edge, err and done go to 1 and no further request is raised. phase_opt is then 0.
- R9: Samples with smp_valid low affect neither slot counting nor any measurement.
- R10: A start pulse while done is high clears done and err, and the whole sequence runs again from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training (taken in idle or after done) |
| smp_valid | input | 1 | ADC sample qualifier |
| smp_data | input | DW | ADC sample code, unsigned |
| step_ack | input | 1 | Phase shifter has applied the requested step |
| step_inc | output | 1 | Request one phase step later |
| step_dec | output | 1 | Request one phase step earlier |
| slot_ofs | output | $clog2(SLOTS) | Slot index carrying channel 1 |
| phase_opt | output | $clog2(PSTEPS) | Midpoint phase, relative to the start position |
| done | output | 1 | Training finished (with or without error) |
| err | output | 1 | No edge found within a full period |

## Verification
The properties assume that the phase shifter answers each request with one step_ack pulse, and never sends an acknowledge while no request is high. They also assume that start arrives only when the block is idle or finished. The stimulus respects this: a single process drives the samples, the acknowledges and start. It raises the acknowledge only in answer to a request it has seen, and it pulses start only after done. The sample model holds the training pattern fixed within each phase setting and uses contrast windows that contain the starting phase. As a result, the reference level is always the full-contrast level that the edge rules assume.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

    // Sequencer states of the alignment controller
    typedef enum logic [2:0] {
        AL_IDLE,
        AL_FIND,
        AL_REF,
        AL_UP_REQ,
        AL_UP_MEAS,
        AL_DN_REQ,
        AL_DN_MEAS,
        AL_DONE
    } al_state_e;

endpackage

// File: rtl/tdm_slot_finder.sv
// Accumulates each slot over NF frames, then picks the slot that stands
// furthest from the mean of all slots.
module tdm_slot_finder #(
    parameter int SLOTS = 8,
    parameter int DW    = 12,
    parameter int NF    = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     en,
    input  logic                     smp_valid,
    input  logic [DW-1:0]            smp_data,
    input  logic [$clog2(SLOTS)-1:0] slot_idx,
    output logic                     found,
    output logic [$clog2(SLOTS)-1:0] ch_slot
);
    localparam int SLW  = $clog2(SLOTS);
    localparam int FCW  = $clog2(NF + 1);
    localparam int SUMW = DW + FCW;
    localparam int TOTW = SUMW + SLW;
    localparam int DEVW = TOTW + 2;

    typedef struct packed {
        logic [SLOTS-1:0][SUMW-1:0] sums;
        logic [FCW-1:0]             frames;
        logic                       full;
        logic                       found;
        logic [SLW-1:0]             ch;
    } fnd_t;

    fnd_t q, d;
    logic [SLW-1:0]  best;
    logic [TOTW-1:0] total;
    logic [DEVW-1:0] scaled, diff, best_dev;

    // Deviation of each slot from the mean, scaled by SLOTS
    always_comb begin
        total = '0;
        for (int k = 0; k < SLOTS; k++) total = total + TOTW'(q.sums[k]);
        best     = '0;
        best_dev = '0;
        for (int k = 0; k < SLOTS; k++) begin
            scaled = DEVW'(q.sums[k]) * DEVW'(SLOTS);
            diff   = scaled - DEVW'(total);
            if (diff[DEVW-1]) diff = -diff;
            if (diff > best_dev) begin
                best_dev = diff;
                best     = SLW'(k);
            end
        end
    end

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (en && !q.full) begin
            if (smp_valid) begin
                d.sums[slot_idx] = q.sums[slot_idx] + SUMW'(smp_data);
                if (slot_idx == SLW'(SLOTS - 1)) begin
                    d.frames = q.frames + 1'b1;
                    if (q.frames == FCW'(NF - 1)) d.full = 1'b1;
                end
            end
        end else if (en && q.full && !q.found) begin
            d.found = 1'b1;
            d.ch    = best;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign found   = q.found;
    assign ch_slot = q.ch;

endmodule

// File: rtl/tdm_contrast_meter.sv
// Measures the channel-1 contrast over NF whole frames after each go pulse.
module tdm_contrast_meter #(
    parameter int SLOTS = 8,
    parameter int DW    = 12,
    parameter int NF    = 64
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          go,
    input  logic [$clog2(SLOTS)-1:0]                      ch_slot,
    input  logic                                          smp_valid,
    input  logic [DW-1:0]                                 smp_data,
    input  logic [$clog2(SLOTS)-1:0]                      slot_idx,
    output logic                                          meas_done,
    output logic [DW+$clog2(SLOTS)+$clog2(NF+1)-1:0]      metric
);
    localparam int SLW = $clog2(SLOTS);
    localparam int FCW = $clog2(NF + 1);
    localparam int XW  = DW + SLW;
    localparam int MW  = XW + FCW;

    typedef struct packed {
        logic           pend;
        logic           run;
        logic [DW-1:0]  x1;
        logic [XW-1:0]  osum;
        logic [FCW-1:0] frames;
        logic [MW-1:0]  acc;
        logic           done;
    } mtr_t;

    mtr_t q, d;
    logic [DW-1:0] x1_n;
    logic [XW-1:0] osum_n, scaled, fm;
    logic          take;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        take   = smp_valid && (q.run || (q.pend && slot_idx == '0));
        x1_n   = (slot_idx == ch_slot) ? smp_data : q.x1;
        osum_n = (slot_idx == ch_slot) ? q.osum : q.osum + XW'(smp_data);
        scaled = XW'(x1_n) * XW'(SLOTS - 1);
        fm     = (scaled >= osum_n) ? scaled - osum_n : osum_n - scaled;
        if (go) begin
            d.pend   = 1'b1;
            d.run    = 1'b0;
            d.x1     = '0;
            d.osum   = '0;
            d.frames = '0;
            d.acc    = '0;
        end else if (take) begin
            d.pend = 1'b0;
            d.run  = 1'b1;
            d.x1   = x1_n;
            d.osum = osum_n;
            if (slot_idx == SLW'(SLOTS - 1)) begin
                d.acc    = q.acc + MW'(fm);
                d.frames = q.frames + 1'b1;
                d.x1     = '0;
                d.osum   = '0;
                if (q.frames == FCW'(NF - 1)) begin
                    d.run  = 1'b0;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign meas_done = q.done;
    assign metric    = q.acc;

endmodule

// File: rtl/tdm_link_aligner.sv
// Slot and phase alignment sequencer for a time-multiplexed sample link.
module tdm_link_aligner
    import tdm_align_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int DW     = 12,
    parameter int NF     = 64,
    parameter int PSTEPS = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      smp_valid,
    input  logic [DW-1:0]             smp_data,
    input  logic                      step_ack,
    output logic                      step_inc,
    output logic                      step_dec,
    output logic [$clog2(SLOTS)-1:0]  slot_ofs,
    output logic [$clog2(PSTEPS)-1:0] phase_opt,
    output logic                      done,
    output logic                      err
);
    localparam int SLW = $clog2(SLOTS);
    localparam int PW  = $clog2(PSTEPS);
    localparam int SCW = $clog2(PSTEPS + 1);
    localparam int MW  = DW + SLW + $clog2(NF + 1);
    localparam logic [PW:0] P_FULL = (PW + 1)'(PSTEPS);

    typedef struct packed {
        al_state_e      st;
        logic [SLW-1:0] slot;
        logic [PW-1:0]  pos;
        logic [SCW-1:0] steps;
        logic [MW-1:0]  refm;
        logic [PW-1:0]  left;
        logic [PW-1:0]  opt;
        logic [SLW-1:0] ch;
        logic           armed;
        logic           done;
        logic           err;
    } seq_t;

    seq_t q, d;

    logic           accept, finder_clr, meter_go;
    logic           fnd;
    logic [SLW-1:0] fnd_slot;
    logic           m_done;
    logic [MW-1:0]  metric;
    logic           below;
    logic [PW-1:0]  pos_up, pos_dn, mid;
    logic [PW:0]    span, midw;

    tdm_slot_finder #(.SLOTS(SLOTS), .DW(DW), .NF(NF)) u_find (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (finder_clr),
        .en        (q.st == AL_FIND),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .slot_idx  (q.slot),
        .found     (fnd),
        .ch_slot   (fnd_slot)
    );

    tdm_contrast_meter #(.SLOTS(SLOTS), .DW(DW), .NF(NF)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (meter_go),
        .ch_slot   (q.ch),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .slot_idx  (q.slot),
        .meas_done (m_done),
        .metric    (metric)
    );

    // Wrapped position arithmetic and half-contrast test
    always_comb begin
        pos_up = (q.pos == PW'(PSTEPS - 1)) ? '0 : q.pos + 1'b1;
        pos_dn = (q.pos == '0) ? PW'(PSTEPS - 1) : q.pos - 1'b1;
        below  = {metric, 1'b0} <= {1'b0, q.refm};
        span   = (q.left >= q.pos) ? {1'b0, q.left} - {1'b0, q.pos}
                                   : {1'b0, q.left} + P_FULL - {1'b0, q.pos};
        midw   = {1'b0, q.pos} + (span >> 1);
        if (midw >= P_FULL) midw = midw - P_FULL;
        mid    = midw[PW-1:0];
    end

    always_comb begin
        d          = q;
        finder_clr = 1'b0;
        meter_go   = 1'b0;
        accept     = start && (q.st == AL_IDLE || q.st == AL_DONE);
        if (smp_valid) d.slot = (q.slot == SLW'(SLOTS - 1)) ? '0 : q.slot + 1'b1;
        case (q.st)
            AL_IDLE, AL_DONE: begin
                if (accept) begin
                    d.st       = AL_FIND;
                    d.slot     = '0;
                    d.pos      = '0;
                    d.steps    = '0;
                    d.opt      = '0;
                    d.ch       = '0;
                    d.done     = 1'b0;
                    d.err      = 1'b0;
                    finder_clr = 1'b1;
                end
            end
            AL_FIND: begin
                if (fnd) begin
                    d.ch     = fnd_slot;
                    d.st     = AL_REF;
                    meter_go = 1'b1;
                end
            end
            AL_REF: begin
                if (m_done) begin
                    d.refm  = metric;
                    d.steps = '0;
                    d.st    = AL_UP_REQ;
                end
            end
            AL_UP_REQ: begin
                if (step_ack) begin
                    d.pos    = pos_up;
                    d.steps  = q.steps + 1'b1;
                    d.st     = AL_UP_MEAS;
                    meter_go = 1'b1;
                end
            end
            AL_UP_MEAS: begin
                if (m_done) begin
                    if (below) begin
                        d.left  = q.pos;
                        d.steps = '0;
                        d.armed = 1'b0;
                        d.st    = AL_DN_REQ;
                    end else if (q.steps == SCW'(PSTEPS)) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                        d.st   = AL_DONE;
                    end else begin
                        d.st = AL_UP_REQ;
                    end
                end
            end
            AL_DN_REQ: begin
                if (step_ack) begin
                    d.pos    = pos_dn;
                    d.steps  = q.steps + 1'b1;
                    d.st     = AL_DN_MEAS;
                    meter_go = 1'b1;
                end
            end
            AL_DN_MEAS: begin
                if (m_done) begin
                    if (below && q.armed) begin
                        d.opt  = mid;
                        d.done = 1'b1;
                        d.st   = AL_DONE;
                    end else begin
                        if (!below) d.armed = 1'b1;
                        if (q.steps == SCW'(PSTEPS)) begin
                            d.err  = 1'b1;
                            d.done = 1'b1;
                            d.st   = AL_DONE;
                        end else begin
                            d.st = AL_DN_REQ;
                        end
                    end
                end
            end
            default: d.st = AL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= AL_IDLE;
        end else begin
            q <= d;
        end
    end

    assign step_inc  = (q.st == AL_UP_REQ);
    assign step_dec  = (q.st == AL_DN_REQ);
    assign slot_ofs  = q.ch;
    assign phase_opt = q.opt;
    assign done      = q.done;
    assign err       = q.err;

endmodule

// File: rtl/tdm_link_aligner_chk.sv
module tdm_link_aligner_chk #(
    parameter int SLOTS  = 8,
    parameter int PSTEPS = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      step_ack,
    input logic                      step_inc,
    input logic                      step_dec,
    input logic [$clog2(SLOTS)-1:0]  slot_ofs,
    input logic [$clog2(PSTEPS)-1:0] phase_opt,
    input logic                      done,
    input logic                      err
);
    // R7: never both directions at once
    p_one_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_inc && step_dec));

    // R7: an unanswered increment request is held
    p_inc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_inc && !step_ack |=> step_inc);

    // R7: an answered increment request is withdrawn
    p_inc_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_inc && step_ack |=> !step_inc && !step_dec);

    // R7: an unanswered decrement request is held
    p_dec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_dec && !step_ack |=> step_dec);

    // R7: an answered decrement request is withdrawn
    p_dec_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_dec && step_ack |=> !step_dec && !step_inc);

    // R8: error always comes with done
    p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R5: no phase request once finished
    p_quiet_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !step_inc && !step_dec);

    // R6: results held while finished and not restarted
    p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(phase_opt) && $stable(slot_ofs) && $stable(err));

    // R10: restart clears completion
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && start |=> !done && !err);

endmodule

bind tdm_link_aligner tdm_link_aligner_chk #(.SLOTS(SLOTS), .PSTEPS(PSTEPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_ack  (step_ack),
    .step_inc  (step_inc),
    .step_dec  (step_dec),
    .slot_ofs  (slot_ofs),
    .phase_opt (phase_opt),
    .done      (done),
    .err       (err)
);

// File: tb/sim_tdm_link_aligner.sv
module sim_tdm_link_aligner;
    localparam int SLOTS  = 8;
    localparam int DW     = 12;
    localparam int NF     = 64;
    localparam int PSTEPS = 64;
    localparam int BASE   = 1000;

    logic clk = 1'b0;
    logic rst_n;
    logic start, smp_valid, step_ack;
    logic [DW-1:0] smp_data;
    logic step_inc, step_dec, done, err;
    logic [2:0] slot_ofs;
    logic [5:0] phase_opt;

    always #4 clk = ~clk;   // 125 MHz

    tdm_link_aligner #(.SLOTS(SLOTS), .DW(DW), .NF(NF), .PSTEPS(PSTEPS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
        .smp_data(smp_data), .step_ack(step_ack), .step_inc(step_inc),
        .step_dec(step_dec), .slot_ofs(slot_ofs), .phase_opt(phase_opt),
        .done(done), .err(err));

    // Scenario of the training source
    int cfg_ch, cfg_c, cfg_wlo, cfg_whi, cfg_amp;
    bit cfg_neg, cfg_flat, cfg_gaps;
    int ph, n_inc, n_dec;
    bit req_start;

    typedef struct {
        int    slot;
        int    phase;
        int    erv;
        int    incs;
        int    decs;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    int checks = 0;
    int errors = 0;

    function automatic int wrapp(int v);
        return ((v % PSTEPS) + PSTEPS) % PSTEPS;
    endfunction

    function automatic int amp_at(int p);
        int dd;
        dd = wrapp(p - cfg_c);
        if (dd >= PSTEPS / 2) dd = dd - PSTEPS;
        if (cfg_flat) return cfg_amp;
        if (dd >= -cfg_wlo && dd <= cfg_whi) return cfg_amp;
        return cfg_amp / 4;
    endfunction

    task automatic check_eq(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Sample source and phase shifter model: one process, driven at negedge
    initial begin
        int sidx, gcnt, wait_c, a;
        sidx = 0; gcnt = 0; wait_c = 0;
        start = 0; smp_valid = 0; smp_data = '0; step_ack = 0;
        forever begin
            @(negedge clk);
            step_ack = 0;
            if (req_start) begin
                start = 1; smp_valid = 0; smp_data = '1;
                sidx = 0; ph = 0; n_inc = 0; n_dec = 0; wait_c = 0;
                req_start = 0;
            end else begin
                start = 0;
                if (rst_n && (step_inc || step_dec)) begin
                    if (wait_c == 2) begin
                        step_ack = 1;
                        wait_c = 0;
                        if (step_inc) begin ph = wrapp(ph + 1); n_inc++; end
                        else          begin ph = wrapp(ph - 1); n_dec++; end
                    end else begin
                        wait_c++;
                    end
                end
                gcnt++;
                if (cfg_gaps && (gcnt % 5 == 3)) begin
                    smp_valid = 0;
                    smp_data  = '1;   // R9: junk while invalid
                end else begin
                    smp_valid = 1;
                    a = amp_at(ph);
                    if (sidx == cfg_ch) smp_data = DW'(cfg_neg ? BASE - a : BASE + a);
                    else                smp_data = DW'(BASE);
                    sidx = (sidx + 1) % SLOTS;
                end
            end
        end
    end

    // Monitor: compares results at each completion
    initial begin
        bit prev;
        exp_t e;
        prev = 0;
        forever begin
            @(negedge clk);
            if (done && !prev) begin
                if (sb_q.size() == 0) begin
                    check_eq("R8 unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check_eq({e.tag, " R2 slot_ofs"}, int'(slot_ofs), e.slot);
                    check_eq({e.tag, " R6 phase_opt"}, int'(phase_opt), e.phase);
                    check_eq({e.tag, " R8 err"}, int'(err), e.erv);
                    check_eq({e.tag, " R4 increments"}, n_inc, e.incs);
                    check_eq({e.tag, " R5 decrements"}, n_dec, e.decs);
                end
            end
            prev = done;
        end
    end

    // Driver: pushes the expected item, then launches a run
    task automatic run_case(string tag, int ch, int c, int wlo, int whi,
                            bit neg, bit flat, bit gaps);
        exp_t e;
        int l, r, span;
        cfg_ch = ch; cfg_c = c; cfg_wlo = wlo; cfg_whi = whi;
        cfg_amp = 400; cfg_neg = neg; cfg_flat = flat; cfg_gaps = gaps;
        e.tag  = tag;
        e.slot = ch;
        if (flat) begin
            e.phase = 0; e.erv = 1; e.incs = PSTEPS; e.decs = 0;
        end else begin
            l = wrapp(c + whi + 1);
            r = wrapp(c - wlo - 1);
            span = wrapp(l - r);
            e.phase = wrapp(r + span / 2);
            e.erv = 0; e.incs = l; e.decs = span;
        end
        sb_q.push_back(e);
        req_start = 1;
        wait (req_start == 0);
        repeat (3) @(negedge clk);
        check_eq({tag, " R10 done cleared after start"}, int'(done), 0);
        wait (done == 1'b1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        req_start = 0;
        cfg_ch = 0; cfg_c = 0; cfg_wlo = 4; cfg_whi = 4; cfg_amp = 400;
        cfg_neg = 0; cfg_flat = 0; cfg_gaps = 0;
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (20) @(negedge clk);
        // R1: idle after reset, nothing requested without start
        check_eq("R1 step_inc", int'(step_inc), 0);
        check_eq("R1 step_dec", int'(step_dec), 0);
        check_eq("R1 done", int'(done), 0);
        check_eq("R1 err", int'(err), 0);

        // R3/R4/R5: symmetric window around the start phase
        run_case("case A", 0, 0, 5, 5, 0, 0, 0);
        // R9: gapped stream with junk, channel below the others
        run_case("case B", 5, 3, 4, 4, 1, 0, 1);
        // R6: centre below zero, asymmetric window, truncating midpoint
        run_case("case C", 7, 60, 2, 5, 0, 0, 1);
        // R8: contrast never halves
        run_case("case D", 2, 0, 4, 4, 0, 1, 0);
        check_eq("R8 no request after error", int'(step_inc | step_dec), 0);

        check_eq("R2 scoreboard drained", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule